// File: doc/BRIEF.md
# Silence and Forced Mute Controller

This block sits between the stereo serial audio receiver and the bridge output stage of a class-D amplifier. It decides when the two bridge pairs must be held in the damped state. In that state both transistor-drive outputs of a pair sit at the grounded level, which shorts the load.

Muting can be forced by an external pin. It is also entered on its own after a long stretch of digital silence on both channels. The block counts consecutive received sample pairs in which both the left and right words are zero. When that run reaches a fixed length, the automatic mute engages. The first pair carrying any non-zero word releases it at once. The final mute decision is registered only when a sample pair is accepted, so every change lines up with a sample boundary. The bridge pairs pass through unchanged whenever the block is not muted.

Top module: `amute_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `mute_o` goes low after that edge and the silence run restarts from zero. After reset, fewer than SILENCE_LEN zero pairs do not mute.
- R2: A pair accepted with `smp_vld` high and both words equal to zero extends the silence run. The edge that accepts the SILENCE_LEN-th consecutive such pair raises `mute_o`.
- R3: A pair accepted with any bit set in either word ends the silence run and clears the automatic mute at the edge that accepts it. A word with only the top (sign) bit set also counts.
- R4: The silence run saturates at SILENCE_LEN. Any number of further zero pairs, including more than twice SILENCE_LEN in total, keeps `mute_o` high.
- R5: `force_mute` is sampled at the edge that accepts a pair. After that edge, `mute_o` equals the sampled `force_mute` OR the automatic mute.
- R6: While `smp_vld` is low, `mute_o` holds its value, whatever `force_mute`, the sample words or the bridge inputs do.
- R7: While `mute_o` is high, both bits of `pwm_l_out` and `pwm_r_out` are 0. While it is low, each output pair equals its input pair in the same cycle.
- R8: A pair in which only one channel is zero does not extend the silence run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Accept strobe for one stereo sample pair |
| smp_left | input | SAMPLE_W | Left channel sample word |
| smp_right | input | SAMPLE_W | Right channel sample word |
| force_mute | input | 1 | External mute request, active high |
| pwm_l_in | input | 2 | Left bridge drive pair from the modulator |
| pwm_r_in | input | 2 | Right bridge drive pair from the modulator |
| mute_o | output | 1 | Final mute state |
| pwm_l_out | output | 2 | Left bridge drive pair after the mute override |
| pwm_r_out | output | 2 | Right bridge drive pair after the mute override |

## Verification
The hardest case to reach from the ports is the saturation of the silence run. Telling saturation apart from a counter that wraps takes more than twice SILENCE_LEN unbroken zero pairs, because a wrapping counter would release the mute only after it rolls over. The stimulus therefore streams over four thousand zero pairs at the default length. It then applies a lone non-zero word and a run of SILENCE_LEN-1 zeros, which shows that the run really restarted.

// File: rtl/amute_pkg.sv
package amute_pkg;

    localparam int unsigned DEF_SAMPLE_W    = 24;
    localparam int unsigned DEF_SILENCE_LEN = 2048;
    localparam int unsigned NUM_CH          = 2;

    typedef struct packed {
        logic hi_side;
        logic lo_side;
    } bridge_pair_t;

    localparam bridge_pair_t PAIR_DAMPED = '{hi_side: 1'b0, lo_side: 1'b0};

    function automatic int unsigned run_width(input int unsigned len);
        return $clog2(len + 1);
    endfunction

    function automatic bridge_pair_t pair_override(input bridge_pair_t p, input logic damp);
        return damp ? PAIR_DAMPED : p;
    endfunction

endpackage

// File: rtl/amute_zero_det.sv
module amute_zero_det #(
    parameter int unsigned SAMPLE_W = amute_pkg::DEF_SAMPLE_W,
    parameter int unsigned CH_CNT   = amute_pkg::NUM_CH
) (
    input  logic [CH_CNT-1:0][SAMPLE_W-1:0] words,
    output logic                            all_zero
);
    logic [CH_CNT-1:0] ch_zero;

    for (genvar c = 0; c < CH_CNT; c++) begin : g_ch
        assign ch_zero[c] = ~|words[c];
    end

    // every channel must be silent for the pair to count
    assign all_zero = &ch_zero;
endmodule

// File: rtl/amute_silence_cnt.sv
module amute_silence_cnt #(
    parameter int unsigned SILENCE_LEN = amute_pkg::DEF_SILENCE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic all_zero,
    output logic full_nxt
);
    localparam int unsigned RUN_W = amute_pkg::run_width(SILENCE_LEN);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SILENCE_LEN);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;

    always_comb begin
        run_d = run_q;
        if (vld) begin
            if (!all_zero) begin
                run_d = '0;
            end else if (run_q != RUN_MAX) begin
                run_d = run_q + RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign full_nxt = (run_d == RUN_MAX);

    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_MAX);

    // R3
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !all_zero) |=> (run_q == '0));

    // R2
    run_step_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && all_zero && run_q != RUN_MAX) |=> (run_q == $past(run_q) + RUN_W'(1)));

    // R6
    run_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(run_q));
endmodule

// File: rtl/amute_out_gate.sv
module amute_out_gate #(
    parameter int unsigned CH_CNT = amute_pkg::NUM_CH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vld,
    input  logic                  force_in,
    input  logic                  auto_full,
    input  logic [CH_CNT-1:0][1:0] pair_in,
    output logic                  mute_q,
    output logic [CH_CNT-1:0][1:0] pair_out
);
    import amute_pkg::*;

    // decision only moves at a sample boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            mute_q <= 1'b0;
        end else if (vld) begin
            mute_q <= force_in | auto_full;
        end
    end

    for (genvar c = 0; c < CH_CNT; c++) begin : g_pair
        bridge_pair_t p_in;
        assign p_in        = bridge_pair_t'(pair_in[c]);
        assign pair_out[c] = pair_override(p_in, mute_q);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !mute_q);

    // R5
    force_take_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && force_in) |=> mute_q);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(mute_q));
endmodule

// File: rtl/amute_ctrl.sv
module amute_ctrl #(
    parameter int unsigned SAMPLE_W    = amute_pkg::DEF_SAMPLE_W,
    parameter int unsigned SILENCE_LEN = amute_pkg::DEF_SILENCE_LEN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                force_mute,
    input  logic [1:0]          pwm_l_in,
    input  logic [1:0]          pwm_r_in,
    output logic                mute_o,
    output logic [1:0]          pwm_l_out,
    output logic [1:0]          pwm_r_out
);
    localparam int unsigned CH_CNT = amute_pkg::NUM_CH;

    logic [CH_CNT-1:0][SAMPLE_W-1:0] words;
    logic [CH_CNT-1:0][1:0]          pair_in;
    logic [CH_CNT-1:0][1:0]          pair_out;
    logic                            all_zero;
    logic                            auto_full;

    assign words[0]   = smp_left;
    assign words[1]   = smp_right;
    assign pair_in[0] = pwm_l_in;
    assign pair_in[1] = pwm_r_in;
    assign pwm_l_out  = pair_out[0];
    assign pwm_r_out  = pair_out[1];

    amute_zero_det #(
        .SAMPLE_W (SAMPLE_W),
        .CH_CNT   (CH_CNT)
    ) zero_i (
        .words    (words),
        .all_zero (all_zero)
    );

    amute_silence_cnt #(
        .SILENCE_LEN (SILENCE_LEN)
    ) run_i (
        .clk      (clk),
        .rst      (rst),
        .vld      (smp_vld),
        .all_zero (all_zero),
        .full_nxt (auto_full)
    );

    amute_out_gate #(
        .CH_CNT (CH_CNT)
    ) gate_i (
        .clk       (clk),
        .rst       (rst),
        .vld       (smp_vld),
        .force_in  (force_mute),
        .auto_full (auto_full),
        .pair_in   (pair_in),
        .mute_q    (mute_o),
        .pair_out  (pair_out)
    );

    // R7
    damped_out_chk: assert property (@(posedge clk) disable iff (rst)
        mute_o |-> (pwm_l_out == 2'b00 && pwm_r_out == 2'b00));

    // R3
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !force_mute && (smp_left != '0 || smp_right != '0)) |=> !mute_o);
endmodule

// File: tb/amute_ctrl_tb.sv
`timescale 1ns/1ps
module amute_ctrl_tb_top;
    localparam int W   = 24;
    localparam int LEN = 2048;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_vld = 1'b0;
    logic [W-1:0] smp_left = '0;
    logic [W-1:0] smp_right = '0;
    logic         force_mute = 1'b0;
    logic [1:0]   pwm_l_in = 2'b10;
    logic [1:0]   pwm_r_in = 2'b01;
    logic         mute_o;
    logic [1:0]   pwm_l_out;
    logic [1:0]   pwm_r_out;

    always #5 clk = ~clk;

    amute_ctrl #(.SAMPLE_W(W), .SILENCE_LEN(LEN)) dut_i (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .smp_left(smp_left), .smp_right(smp_right),
        .force_mute(force_mute),
        .pwm_l_in(pwm_l_in), .pwm_r_in(pwm_r_in),
        .mute_o(mute_o), .pwm_l_out(pwm_l_out), .pwm_r_out(pwm_r_out)
    );

    typedef struct {
        logic  mute;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   run   = 0;
    bit   done  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // outputs against an expected mute level, pass-through pairs included (R7)
    task automatic check_outs(input logic m, input string tag);
        logic [1:0] el, er;
        el = m ? 2'b00 : pwm_l_in;
        er = m ? 2'b00 : pwm_r_in;
        check(mute_o === m, tag, int'(mute_o), int'(m));
        check(pwm_l_out === el && pwm_r_out === er, {tag, "/R7"},
              int'({pwm_l_out, pwm_r_out}), int'({el, er}));
    endtask

    // driver: model from the requirements, push expectation, pulse the strobe
    task automatic send(input logic [W-1:0] lv, input logic [W-1:0] rv, input string tag);
        exp_t e;
        @(negedge clk);
        smp_left  = lv;
        smp_right = rv;
        smp_vld   = 1'b1;
        if (lv == '0 && rv == '0) begin
            if (run < LEN) run++;
        end else begin
            run = 0;
        end
        e.mute = force_mute | (run == LEN);
        e.tag  = tag;
        exp_q.push_back(e);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic zeros(input int n, input string tag);
        for (int i = 0; i < n; i++) send('0, '0, tag);
    endtask

    // monitor: one expectation per accepted pair, read after the accepting edge
    initial begin
        forever begin
            @(posedge clk);
            if (smp_vld && !rst) begin
                exp_t e;
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "queue", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    check_outs(e.mute, e.tag);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_outs(1'b0, "R1 reset");

        // audio playing: pass-through under several pair patterns
        send(24'h000123, 24'h7FFFFF, "R7 play");
        pwm_l_in = 2'b01; pwm_r_in = 2'b11;
        send(24'hFFFFFF, 24'h000001, "R7 play");
        #1 check_outs(1'b0, "R7 live");

        // silence reaching the threshold
        zeros(LEN - 1, "R2 below");
        zeros(1, "R2 reach");
        // saturation: well beyond twice the threshold
        zeros(LEN + 60, "R4 hold");
        // sign bit alone wakes up
        send('0, 24'h800000, "R3 sign");
        zeros(LEN - 1, "R4 restart");
        send(24'h000004, '0, "R3 left");

        // only one channel silent never counts
        for (int i = 0; i < LEN + 2; i++) send('0, 24'h000005, "R8 half");
        send('0, '0, "R8 one");

        // idle cycles: force and words move, mute holds
        @(negedge clk);
        force_mute = 1'b1;
        smp_left   = 24'h0;
        smp_right  = 24'h0;
        repeat (3) @(negedge clk);
        check_outs(1'b0, "R6 idle");
        send(24'h000010, 24'h000020, "R5 force");
        force_mute = 1'b0;
        repeat (3) @(negedge clk);
        check_outs(1'b1, "R6 idle");
        send(24'h000010, 24'h000020, "R5 release");

        // force released while auto-muted keeps the mute
        zeros(LEN, "R2 again");
        force_mute = 1'b1;
        send('0, '0, "R5 both");
        force_mute = 1'b0;
        send('0, '0, "R5 auto");

        // reset in the middle of silence
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run = 0;
        @(negedge clk);
        check_outs(1'b0, "R1 midreset");
        zeros(LEN - 1, "R1 cleared");
        zeros(1, "R2 final");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "queue drain", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule